// File: doc/BRIEF.md
# Self-Timed Redundant Successive-Approximation Sequencer

This block is the digital controller for a successive-approximation converter that uses 15 decisions to reach 12-bit resolution. It runs on a fast system clock, but takes only one timing event from outside: the falling edge of the external sample clock, which ends tracking. After that edge, each decision step is self-timed. A programmable settle delay runs first. The comparator is then enabled and the block waits for its ready flag, which is the XOR of the two complementary comparator outputs. The block latches the decision, drives the bottom-plate switch of the current capacitor element, and moves to the next step. As soon as the fifteenth decision is latched, the block goes back to tracking by itself.

Each of the 15 elements has a pair of switch controls. When both controls are low, the element sits at mid-rail. When one control is high, the element is connected to the positive or the negative reference. All elements sit at mid-rail while tracking. Switching is monotonic and mid-rail based: a decided element moves to one reference and stays there until the conversion ends. The comparator might never answer. In that case, a timeout forces a default decision so that the conversion still completes. The raw decision word is presented with a one-cycle done strobe. Code reconstruction from the redundant word is left to the consumer.

The controller has three states:
- ST_TRACK: tracking; the comparator is off.
- ST_SETTLE: the settle count runs, and the block waits for the ready flag to drop.
- ST_COMPARE: the comparator is enabled.

It has four transitions:
- TRACK→SETTLE, taken on a sample-clock fall.
- SETTLE→COMPARE, taken when the settle count is spent and ready is low.
- COMPARE→SETTLE, taken on ready or timeout while decisions remain.
- COMPARE→TRACK, taken on the final decision.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, `track` is 1, `cmp_clk` is 0, `sw_up` and `sw_dn` are all 0, `done` is 0 and `raw_word` is 0.
- R2: A conversion starts only on a falling edge of `samp_clk` seen while tracking. Edges of `samp_clk` during a conversion are ignored: they start no extra conversion and do not alter the result.
- R3: Every conversion raises `cmp_clk` exactly 15 times. Bit 14 of `raw_word` holds the first decision and bit 0 the last. `done` is high for exactly one clock cycle.
- R4: The comparator is ready only when exactly one of `cmp_p`/`cmp_n` is high, so both high counts as not ready. The decision is 1 when `cmp_p` is high at ready.
- R5: While `track` is 1, all switch controls are 0. Element k is 0 (mid-rail) until step k is decided. A decision of 1 then sets `sw_dn[k]` and a decision of 0 sets `sw_up[k]`. The setting holds until the conversion ends. `sw_up[k]` and `sw_dn[k]` are never both high.
- R6: `cmp_clk` falls after ready is seen. It rises again only after at least `settle_cnt`+1 clock cycles low.
- R7: If ready does not arrive within TMO+1 cycles of `cmp_clk` high, the decision is forced to 0 and the conversion continues.
- R8: `done` coincides with `track` high: tracking resumes in the cycle the word is presented.
- R9: With an ideal comparator whose decision is the sign (positive means 1) of the input minus the switched element weights, `raw_word` equals the bit sequence of that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_clk | input | 1 | External sample clock; its fall ends tracking |
| cmp_p | input | 1 | Comparator positive output |
| cmp_n | input | 1 | Comparator negative output |
| settle_cnt | input | SW | Settle delay in clock ticks before each compare |
| track | output | 1 | High while the input is being tracked |
| cmp_clk | output | 1 | Comparator enable; low resets the comparator |
| sw_up | output | NCYC | Element k bottom plate to positive reference |
| sw_dn | output | NCYC | Element k bottom plate to negative reference |
| raw_word | output | NCYC | Raw decisions, bit 14 first |
| done | output | 1 | One-cycle strobe, raw_word valid |

## Verification
The hardest situations to reach from the ports are a comparator that never resolves and one that passes through a both-high state before settling. The bench comparator model has two modes for these. In the silent mode it refuses to answer on one chosen step (the first, a middle one or the last), so the forced decision feeds back into the remaining residue. In the both-high mode it raises both outputs for several cycles before the true answer. Sample-clock edges injected mid-conversion check that they are ignored. The input is swept across the full range under several settle counts, with each word predicted arithmetically.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_TRACK   = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_COMPARE = 2'd2
    } sar_state_t;
endpackage

// File: rtl/sar_sync.sv
// Multi-stage synchronizer with a falling-edge pulse on the synchronized value.
module sar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_val,
    input  logic d,
    output logic q,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {(STAGES+1){rst_val}};
        else        sh <= {sh[STAGES-1:0], d};
    end

    assign q    = sh[STAGES-1];
    assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/sar_timer.sv
// Loadable down-counter; zero is high once the loaded count has run out.
module sar_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (load)     cnt <= val;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sar_bitreg.sv
// Per-element decision and activity storage.
module sar_bitreg #(
    parameter int N  = 15,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    input  logic          bit_in,
    output logic [N-1:0]  dec,
    output logic [N-1:0]  act
);
    for (genvar g = 0; g < N; g++) begin : g_elem
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dec[g] <= 1'b0;
                act[g] <= 1'b0;
            end else if (clr) begin
                dec[g] <= 1'b0;
                act[g] <= 1'b0;
            end else if (wr && idx == IW'(g)) begin
                dec[g] <= bit_in;
                act[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int NCYC = 15,
    parameter int SW   = 4,
    parameter int TMO  = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            samp_clk,
    input  logic            cmp_p,
    input  logic            cmp_n,
    input  logic [SW-1:0]   settle_cnt,
    output logic            track,
    output logic            cmp_clk,
    output logic [NCYC-1:0] sw_up,
    output logic [NCYC-1:0] sw_dn,
    output logic [NCYC-1:0] raw_word,
    output logic            done
);
    localparam int IW  = $clog2(NCYC);
    localparam int TMW = $clog2(TMO + 1);
    localparam int TW  = (TMW > SW) ? TMW : SW;

    sar_state_t     state, nstate;
    logic [IW-1:0]  idx;
    logic           samp_fall, samp_s;
    logic           rdy_s, rdy_fall_unused;
    logic           dec_s, dec_fall_unused;
    logic           tmr_load, tmr_zero;
    logic [TW-1:0]  tmr_val;
    logic           bit_wr, bit_val, last;
    logic [NCYC-1:0] dec, act;

    sar_sync #(.STAGES(2)) u_samp_sync (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b1), .d(samp_clk),
        .q(samp_s), .fall(samp_fall)
    );
    sar_sync #(.STAGES(2)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b0), .d(cmp_p ^ cmp_n),
        .q(rdy_s), .fall(rdy_fall_unused)
    );
    sar_sync #(.STAGES(2)) u_dec_sync (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b0), .d(cmp_p),
        .q(dec_s), .fall(dec_fall_unused)
    );

    sar_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );

    sar_bitreg #(.N(NCYC)) u_bits (
        .clk(clk), .rst_n(rst_n), .clr(nstate == ST_TRACK), .wr(bit_wr),
        .idx(idx), .bit_in(bit_val), .dec(dec), .act(act)
    );

    assign last = (idx == '0);

    // Transition logic
    always_comb begin
        nstate   = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        bit_wr   = 1'b0;
        bit_val  = 1'b0;
        unique case (state)
            ST_TRACK: begin
                if (samp_fall) begin
                    nstate   = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(settle_cnt);
                end
            end
            ST_SETTLE: begin
                if (tmr_zero && !rdy_s) begin
                    nstate   = ST_COMPARE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TMO);
                end
            end
            ST_COMPARE: begin
                if (rdy_s || tmr_zero) begin
                    bit_wr  = 1'b1;
                    bit_val = rdy_s & dec_s;
                    if (last) begin
                        nstate = ST_TRACK;
                    end else begin
                        nstate   = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(settle_cnt);
                    end
                end
            end
            default: nstate = ST_TRACK;
        endcase
    end

    // State register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_TRACK;
            idx      <= IW'(NCYC - 1);
            done     <= 1'b0;
            raw_word <= '0;
        end else begin
            state <= nstate;
            done  <= 1'b0;
            if (state == ST_TRACK) begin
                idx <= IW'(NCYC - 1);
            end else if (bit_wr) begin
                if (last) begin
                    done     <= 1'b1;
                    raw_word <= {dec[NCYC-1:1], bit_val};
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        track   = (state == ST_TRACK);
        cmp_clk = (state == ST_COMPARE);
        sw_up   = act & ~dec;
        sw_dn   = act & dec;
    end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NCYC = 15,
    parameter int SW   = 4,
    parameter int TMO  = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic [SW-1:0]   settle_cnt,
    input logic            track,
    input logic            cmp_clk,
    input logic [NCYC-1:0] sw_up,
    input logic [NCYC-1:0] sw_dn,
    input logic            done
);
    logic [15:0] lo_cnt, hi_cnt, rise_cnt;
    logic        cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt   <= '0;
            hi_cnt   <= '0;
            rise_cnt <= '0;
            cmp_q    <= 1'b0;
        end else begin
            cmp_q <= cmp_clk;
            if (cmp_clk) lo_cnt <= '0;
            else if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
            if (!cmp_clk) hi_cnt <= '0;
            else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
            if (track && !done) rise_cnt <= '0;
            else if (cmp_clk && !cmp_q) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    p_track_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        track |-> (sw_up == '0 && sw_dn == '0));

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_up & sw_dn) == '0);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!track && !$past(track)) |->
            (($past(sw_up) & ~sw_up) == '0 && ($past(sw_dn) & ~sw_dn) == '0));

    p_done_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> track);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rise_cnt == 16'(NCYC));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        track |-> !cmp_clk);

    p_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_clk) |-> lo_cnt > 16'(settle_cnt));

    p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_clk |-> hi_cnt <= 16'(TMO));
endmodule

bind sar_seq_ctrl sar_seq_chk #(.NCYC(NCYC), .SW(SW), .TMO(TMO)) u_chk (
    .clk(clk), .rst_n(rst_n), .settle_cnt(settle_cnt), .track(track),
    .cmp_clk(cmp_clk), .sw_up(sw_up), .sw_dn(sw_dn), .done(done)
);

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;
    localparam int NC  = 15;
    localparam int SW  = 4;
    localparam int TMO = 20;

    logic clk = 1'b0, rst_n = 1'b0, samp_clk = 1'b1, cmp_p = 1'b0, cmp_n = 1'b0;
    logic [SW-1:0] settle_cnt = 4'd2;
    logic track, cmp_clk, done;
    logic [NC-1:0] sw_up, sw_dn, raw_word;

    int checks = 0, errors = 0, cycles = 0;
    int vin_cur = 0, silent_c = -1, cmp_num = 0;
    bit both_first = 1'b0;

    sar_seq_ctrl #(.NCYC(NC), .SW(SW), .TMO(TMO)) u_sar_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .samp_clk(samp_clk), .cmp_p(cmp_p), .cmp_n(cmp_n),
        .settle_cnt(settle_cnt), .track(track), .cmp_clk(cmp_clk), .sw_up(sw_up),
        .sw_dn(sw_dn), .raw_word(raw_word), .done(done)
    );

    always #5 clk = ~clk;

    function automatic int wgt(int k);
        case (k)
            14: return 1024; 13: return 512; 12: return 256; 11: return 128;
            10: return 64;   9: return 32;   8: return 32;   7: return 16;
            6: return 8;     5: return 8;    4: return 4;    3: return 2;
            2: return 2;     default: return 1;
        endcase
    endfunction

    function automatic logic [NC-1:0] ideal(int vin, int silent);
        logic [NC-1:0] w = '0;
        int r = vin;
        for (int c = 0; c < NC; c++) begin
            int k = NC - 1 - c;
            bit d = (c == silent) ? 1'b0 : (r > 0);
            w[k] = d;
            if (d) r -= wgt(k); else r += wgt(k);
        end
        return w;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Comparator model: ideal residue sign after a random delay
    initial begin
        forever begin
            int n, r;
            @(posedge cmp_clk);
            n = cmp_num;
            cmp_num++;
            repeat ($urandom_range(1, 5)) @(negedge clk);
            if (both_first) begin
                cmp_p = 1'b1; cmp_n = 1'b1;
                repeat (3) @(negedge clk);
            end
            if (n != silent_c) begin
                r = vin_cur;
                for (int k = 0; k < NC; k++) begin
                    if (sw_dn[k]) r -= wgt(k);
                    if (sw_up[k]) r += wgt(k);
                end
                cmp_p = (r > 0);
                cmp_n = !(r > 0);
            end else begin
                cmp_p = 1'b0; cmp_n = 1'b0;
            end
            wait (!cmp_clk);
            @(negedge clk);
            cmp_p = 1'b0; cmp_n = 1'b0;
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                chk(1'b0, "watchdog", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic convert(int vin, int silent, bit glitch, string req);
        int rises = 0, lowrun = 0, minlow = 1000, t = 0;
        bit prev_cmp = 1'b0, mono_ok = 1'b1, excl_ok = 1'b1, got = 1'b0;
        logic [NC-1:0] pu = '0, pd = '0;
        logic [NC-1:0] exp_w = ideal(vin, silent);
        vin_cur = vin; silent_c = silent; cmp_num = 0;
        @(negedge clk); samp_clk = 1'b1;
        repeat (4) @(negedge clk);
        samp_clk = 1'b0;
        while (!got && t < 4000) begin
            @(negedge clk);
            t++;
            if (glitch && t == 40) samp_clk = 1'b1;
            if (glitch && t == 70) samp_clk = 1'b0;
            if (cmp_clk && !prev_cmp) begin
                rises++;
                if (lowrun < minlow) minlow = lowrun;
            end
            if (cmp_clk) lowrun = 0; else if (!track) lowrun++;
            if (!track && ((pu & ~sw_up) != 0 || (pd & ~sw_dn) != 0)) mono_ok = 1'b0;
            if ((sw_up & sw_dn) != 0) excl_ok = 1'b0;
            pu = sw_up; pd = sw_dn; prev_cmp = cmp_clk;
            if (done) got = 1'b1;
        end
        chk(got, {req, " done seen"}, int'(got), 1);
        chk(raw_word == exp_w, {req, " word"}, int'(raw_word), int'(exp_w));
        chk(rises == NC, "R3 compare count", rises, NC);
        chk(track == 1'b1, "R8 track at done", int'(track), 1);
        chk(sw_up == '0 && sw_dn == '0, "R5 mid-rail at done", int'(sw_up | sw_dn), 0);
        chk(mono_ok && excl_ok, "R5 monotonic/exclusive", int'({mono_ok, excl_ok}), 3);
        chk(minlow >= int'(settle_cnt) + 1, "R6 settle", minlow, int'(settle_cnt) + 1);
        @(negedge clk);
        chk(done == 1'b0, "R3 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(track == 1'b1 && cmp_clk == 1'b0 && done == 1'b0, "R1 control reset",
            int'({track, cmp_clk, done}), 4);
        chk(sw_up == '0 && sw_dn == '0 && raw_word == '0, "R1 data reset",
            int'(sw_up | sw_dn | raw_word), 0);

        // R9 sweep over input and settle counts
        for (int s = 0; s < 3; s++) begin
            settle_cnt = (s == 0) ? 4'd0 : (s == 1) ? 4'd3 : 4'd9;
            for (int v = -2100; v <= 2100; v += 150) convert(v, -1, 1'b0, "R9 sweep");
        end
        settle_cnt = 4'd1;
        convert(0, -1, 1'b0, "R9 zero");
        convert(1, -1, 1'b0, "R9 plus one");
        convert(-1, -1, 1'b0, "R9 minus one");
        convert(2047, -1, 1'b0, "R3 bit order full scale");

        // R7 silent comparator on first, middle, last step
        convert(900, 0, 1'b0, "R7 timeout first");
        convert(-333, 7, 1'b0, "R7 timeout middle");
        convert(555, 14, 1'b0, "R7 timeout last");

        // R4 both outputs high before resolving
        both_first = 1'b1;
        convert(1234, -1, 1'b0, "R4 both-high");
        convert(-1500, -1, 1'b0, "R4 both-high neg");
        both_first = 1'b0;

        // R2 sample-clock edges during conversion ignored
        convert(777, -1, 1'b1, "R2 glitch");
        begin
            bit quiet = 1'b1;
            repeat (60) begin
                @(negedge clk);
                if (!track || cmp_clk || done) quiet = 1'b0;
            end
            chk(quiet, "R2 no extra conversion", int'(quiet), 1);
        end
        convert(-42, -1, 1'b1, "R2 glitch neg");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule